// File: doc/BRIEF.md
# Four-Stage Pipeline Stall and Squash Controller

This block is the control path for an in-order pipeline with four stages: fetch (IF), decode (ID), execute (EX) and write-back (WB). It keeps a valid bit, an instruction tag, a branch target tag and a small set of decode flags in each stage's input register. Each cycle every entry moves one stage forward while the fetch side offers a new instruction to IF. The datapath, ALU, register file and memories sit outside the block.

Three things interrupt the steady flow. An operation marked multi-cycle stays in EX for a fixed number of cycles. A conditional branch in EX waits while the instruction that sets its condition code is still in WB. A taken branch or jump leaving EX redirects fetch for one cycle and turns younger wrong-path instructions into bubbles. It keeps exactly one younger instruction as the delay slot. During any hold, IF, ID and EX freeze, fetch is disabled and a bubble enters WB.

The fetch side is assumed to present the delay-slot instruction no later than the cycle in which the branch leaves EX. It also presents the target instruction in the cycle after the redirect strobe. A taken branch is never placed in a delay slot.

Top module: `pipe_stall_squash_ctl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four stage valid bits clear. After that edge `fetch_en_o` is 1 and `redirect_o` is 0.
- R2: With no hold active, each rising edge moves the entries forward: the offered instruction goes to IF, IF to ID, ID to EX and EX to WB. The offered instruction's valid bit is `in_valid`. Stage i of `stg_vld_o` / `stg_tag_o` has index 0 = IF, 1 = ID, 2 = EX, 3 = WB, and tag slice i is bits [i*TAG_W +: TAG_W].
- R3: An instruction with `in_multi` set stays in EX for MC_CYC cycles (default 3). During the first MC_CYC-1 of them, `fetch_en_o` is 0, IF, ID and EX keep their contents, the offered instruction is ignored and WB receives an invalid entry.
- R4: A conditional branch (`in_cond`) in EX stalls for exactly one cycle while WB holds a valid instruction that sets the condition code (`in_sets_cc`). The stall freezes stages as in R3. With no such producer in WB it does not stall.
- R5: While a valid branch with `in_taken` set is in EX and no hold is active, `redirect_o` is 1 and `redirect_tag_o` equals that branch's `in_target`. The strobe lasts one cycle.
- R6: On the edge where a redirecting branch leaves EX, the oldest valid entry among ID, IF and the offered instruction is kept as the delay slot. Every younger one among them becomes invalid.
- R7: A branch with `in_taken` clear raises no redirect and squashes nothing.
- R8: A multi-cycle instruction in the delay slot is not squashed and is still held in EX for the full MC_CYC cycles.
- R9: A squashed entry never shows as valid in WB. A squashed condition-code setter never causes an R4 stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Fetch side offers an instruction |
| in_tag | input | TAG_W | Tag of the offered instruction |
| in_multi | input | 1 | Offered instruction occupies EX for MC_CYC cycles |
| in_branch | input | 1 | Offered instruction is a branch or jump |
| in_cond | input | 1 | Offered branch reads the condition code |
| in_sets_cc | input | 1 | Offered instruction writes the condition code in WB |
| in_taken | input | 1 | Offered branch resolves as taken |
| in_target | input | TAG_W | Tag of the branch target |
| fetch_en_o | output | 1 | Offered instruction is accepted at the next edge |
| stg_vld_o | output | 4 | Valid bits, index 0 = IF to 3 = WB |
| stg_tag_o | output | 4*TAG_W | Stage tags, slice i = stage i |
| redirect_o | output | 1 | Taken branch leaving EX this cycle |
| redirect_tag_o | output | TAG_W | Target tag for the fetch side |

## Verification
Every stage output comes from a register, so a value offered in one cycle shows in IF after one rising edge and reaches WB after four. A multi-cycle operation adds MC_CYC-1 edges to that, and a condition-code stall adds one. `redirect_o` and `fetch_en_o` are decoded from the stage registers and are valid during the same cycle the branch or held instruction sits in EX. The bench drives inputs on the falling edge and samples on the following falling edge, so each check sees exactly one rising edge's effect. For every check it counts the edges by hand from the requirement.

// File: rtl/pipe_ctl_pkg.sv
// Package: shared types for the four-stage pipeline controller.
// Assumes stage order IF, ID, EX, WB maps onto indices 0..3.
package pipe_ctl_pkg;

    localparam int NUM_STG = 4;
    localparam int STG_IF  = 0;
    localparam int STG_ID  = 1;
    localparam int STG_EX  = 2;
    localparam int STG_WB  = 3;

    // Decode flags carried with every instruction through the pipe.
    typedef struct packed {
        logic multi;    // occupies EX for several cycles
        logic branch;   // branch or jump
        logic cond;     // reads the condition code
        logic sets_cc;  // writes the condition code in WB
        logic taken;    // resolves as taken
    } op_flags_t;

endpackage

// File: rtl/pipe_stage_reg.sv
// Module: one stage input register (valid, tag, target, flags).
// Loads its inputs when load is high; reset clears the valid bit and
// zeroes the payload. Assumes the caller has already masked d_valid
// for squash or bubble insertion.
module pipe_stage_reg
    import pipe_ctl_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             d_valid,
    input  logic [TAG_W-1:0] d_tag,
    input  logic [TAG_W-1:0] d_target,
    input  op_flags_t        d_flags,
    output logic             q_valid,
    output logic [TAG_W-1:0] q_tag,
    output logic [TAG_W-1:0] q_target,
    output op_flags_t        q_flags
);

    // Capture the next entry, or keep the current one when not loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid  <= 1'b0;
            q_tag    <= '0;
            q_target <= '0;
            q_flags  <= '0;
        end else if (load) begin
            q_valid  <= d_valid;
            q_tag    <= d_tag;
            q_target <= d_target;
            q_flags  <= d_flags;
        end
    end

endmodule

// File: rtl/pipe_hazard_unit.sv
// Module: decides when the instruction in EX must stay there.
// Two sources: a multi-cycle operation that has not yet spent MC_CYC
// cycles in EX, and a conditional branch whose condition-code producer
// is still in WB. Assumes MC_CYC >= 2 and that EX is reloaded whenever
// hold is low.
module pipe_hazard_unit #(
    parameter int MC_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ex_valid,
    input  logic ex_multi,
    input  logic ex_cond,
    input  logic wb_valid,
    input  logic wb_sets_cc,
    output logic hold
);

    localparam int CNT_W = (MC_CYC > 2) ? $clog2(MC_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MC_CYC - 1);

    logic [CNT_W-1:0] mc_cnt;
    logic             mc_hold;
    logic             cc_hold;

    // Multi-cycle hold lasts until the counter reaches its final value.
    assign mc_hold = ex_valid && ex_multi && (mc_cnt != CNT_LAST);
    // Condition-code wait while the producer is still in write-back.
    assign cc_hold = ex_valid && ex_cond && wb_valid && wb_sets_cc;
    assign hold    = mc_hold || cc_hold;

    // Count the cycles the current EX entry has already been held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_cnt <= '0;
        end else if (!hold) begin
            mc_cnt <= '0;
        end else if (mc_hold) begin
            mc_cnt <= mc_cnt + 1'b1;
        end
    end

    // The hold counter never runs past the configured EX occupancy.
    assert_mc_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mc_cnt) < MC_CYC);

    // A condition-code wait puts a bubble into WB on the following cycle.
    assert_cc_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cc_hold |=> !wb_valid);

endmodule

// File: rtl/pipe_squash_unit.sv
// Module: turns a taken branch in EX into a redirect strobe and the
// squash masks for younger instructions. The oldest valid entry younger
// than the branch (ID, then IF, then the offered instruction) is the
// delay slot and survives. Assumes no taken branch sits in a delay slot.
module pipe_squash_unit #(
    parameter int TAG_W = 8
) (
    input  logic             hold,
    input  logic             ex_valid,
    input  logic             ex_branch,
    input  logic             ex_taken,
    input  logic [TAG_W-1:0] ex_target,
    input  logic             id_valid,
    input  logic             if_valid,
    output logic             redirect,
    output logic [TAG_W-1:0] redirect_tag,
    output logic             kill_if,
    output logic             kill_in
);

    // Redirect only when the branch actually leaves EX this cycle.
    assign redirect     = ex_valid && ex_branch && ex_taken && !hold;
    assign redirect_tag = ex_target;

    // Squash everything younger than the first valid delay-slot candidate.
    always_comb begin
        kill_if = redirect && id_valid;
        kill_in = redirect && (id_valid || if_valid);
    end

endmodule

// File: rtl/pipe_stall_squash_ctl.sv
// Module: top of the four-stage pipeline stall and squash controller.
// Holds per-stage valid/tag/flag registers, freezes IF..EX on a hold
// while a bubble enters WB, and squashes wrong-path entries behind a
// taken branch while keeping one delay slot. Assumes the fetch side
// keeps offering the same instruction while fetch_en_o is low.
module pipe_stall_squash_ctl
    import pipe_ctl_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int MC_CYC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [TAG_W-1:0]         in_tag,
    input  logic                     in_multi,
    input  logic                     in_branch,
    input  logic                     in_cond,
    input  logic                     in_sets_cc,
    input  logic                     in_taken,
    input  logic [TAG_W-1:0]         in_target,
    output logic                     fetch_en_o,
    output logic [NUM_STG-1:0]       stg_vld_o,
    output logic [NUM_STG*TAG_W-1:0] stg_tag_o,
    output logic                     redirect_o,
    output logic [TAG_W-1:0]         redirect_tag_o
);

    logic             cur_vld [NUM_STG];
    logic [TAG_W-1:0] cur_tag [NUM_STG];
    logic [TAG_W-1:0] cur_tgt [NUM_STG];
    op_flags_t        cur_flg [NUM_STG];

    logic             nxt_vld [NUM_STG];
    logic [TAG_W-1:0] nxt_tag [NUM_STG];
    logic [TAG_W-1:0] nxt_tgt [NUM_STG];
    op_flags_t        nxt_flg [NUM_STG];

    logic [NUM_STG-1:0] drop;
    logic               hold;
    logic               kill_if;
    logic               kill_in;
    op_flags_t          in_flags;

    // Bundle the offered instruction's decode flags.
    always_comb begin
        in_flags.multi   = in_multi;
        in_flags.branch  = in_branch;
        in_flags.cond    = in_cond;
        in_flags.sets_cc = in_sets_cc;
        in_flags.taken   = in_taken;
    end

    pipe_hazard_unit #(
        .MC_CYC (MC_CYC)
    ) i_hazard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ex_valid   (cur_vld[STG_EX]),
        .ex_multi   (cur_flg[STG_EX].multi),
        .ex_cond    (cur_flg[STG_EX].cond),
        .wb_valid   (cur_vld[STG_WB]),
        .wb_sets_cc (cur_flg[STG_WB].sets_cc),
        .hold       (hold)
    );

    pipe_squash_unit #(
        .TAG_W (TAG_W)
    ) i_squash (
        .hold         (hold),
        .ex_valid     (cur_vld[STG_EX]),
        .ex_branch    (cur_flg[STG_EX].branch),
        .ex_taken     (cur_flg[STG_EX].taken),
        .ex_target    (cur_tgt[STG_EX]),
        .id_valid     (cur_vld[STG_ID]),
        .if_valid     (cur_vld[STG_IF]),
        .redirect     (redirect_o),
        .redirect_tag (redirect_tag_o),
        .kill_if      (kill_if),
        .kill_in      (kill_in)
    );

    // Per-stage invalidation: squash into IF and ID, bubble into WB.
    always_comb begin
        drop         = '0;
        drop[STG_IF] = kill_in;
        drop[STG_ID] = kill_if;
        drop[STG_WB] = hold;
    end

    assign fetch_en_o = !hold;

    for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
        logic load;

        if (g == 0) begin : g_src_in
            // IF takes the offered instruction.
            always_comb begin
                nxt_vld[g] = in_valid && !drop[g];
                nxt_tag[g] = in_tag;
                nxt_tgt[g] = in_target;
                nxt_flg[g] = in_flags;
            end
        end else begin : g_src_prev
            // Later stages take the entry of the stage before them.
            always_comb begin
                nxt_vld[g] = cur_vld[g-1] && !drop[g];
                nxt_tag[g] = cur_tag[g-1];
                nxt_tgt[g] = cur_tgt[g-1];
                nxt_flg[g] = cur_flg[g-1];
            end
        end

        if (g == NUM_STG - 1) begin : g_load_always
            assign load = 1'b1;
        end else begin : g_load_gated
            assign load = !hold;
        end

        pipe_stage_reg #(
            .TAG_W (TAG_W)
        ) i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .d_valid  (nxt_vld[g]),
            .d_tag    (nxt_tag[g]),
            .d_target (nxt_tgt[g]),
            .d_flags  (nxt_flg[g]),
            .q_valid  (cur_vld[g]),
            .q_tag    (cur_tag[g]),
            .q_target (cur_tgt[g]),
            .q_flags  (cur_flg[g])
        );

        assign stg_vld_o[g]                = cur_vld[g];
        assign stg_tag_o[g*TAG_W +: TAG_W] = cur_tag[g];
    end

    // Payload bits that leave the pipe without further use.
    logic unused_payload;
    assign unused_payload = ^{cur_tgt[STG_WB], cur_flg[STG_WB].multi,
                              cur_flg[STG_WB].branch, cur_flg[STG_WB].cond,
                              cur_flg[STG_WB].taken};

    // Reset leaves every stage empty on the following cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (stg_vld_o == '0));

    // A hold freezes IF..EX and puts an empty entry into WB.
    assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(stg_vld_o[STG_EX:STG_IF])
                  && $stable(stg_tag_o[3*TAG_W-1:0])
                  && !stg_vld_o[STG_WB]));

    // The redirect strobe never lasts two cycles in a row.
    assert_redirect_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    // The edge after a redirect, IF holds no wrong-path entry unless
    // nothing older than the offered instruction was available as the slot.
    assert_squash_if_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && (stg_vld_o[STG_ID] || stg_vld_o[STG_IF])) |=> !stg_vld_o[STG_IF]);

endmodule

// File: tb/test_pipe_stall_squash_ctl.sv
`timescale 1ns/1ps
module test_pipe_stall_squash_ctl;

    localparam int TAG_W  = 8;
    localparam int MC_CYC = 3;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid, in_multi, in_branch, in_cond, in_sets_cc, in_taken;
    logic [TAG_W-1:0]     in_tag, in_target;
    logic                 fetch_en_o, redirect_o;
    logic [3:0]           stg_vld_o;
    logic [4*TAG_W-1:0]   stg_tag_o;
    logic [TAG_W-1:0]     redirect_tag_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pipe_stall_squash_ctl #(.TAG_W(TAG_W), .MC_CYC(MC_CYC)) i_pipe_stall_squash_ctl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_multi(in_multi), .in_branch(in_branch), .in_cond(in_cond),
        .in_sets_cc(in_sets_cc), .in_taken(in_taken), .in_target(in_target),
        .fetch_en_o(fetch_en_o), .stg_vld_o(stg_vld_o), .stg_tag_o(stg_tag_o),
        .redirect_o(redirect_o), .redirect_tag_o(redirect_tag_o)
    );

    function automatic int tag_at(int s);
        return int'(stg_tag_o[s*TAG_W +: TAG_W]);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Offer one instruction, then let one rising edge pass.
    task automatic offer(bit v, int tag, bit m, bit b, bit c, bit s, bit t, int tgt);
        in_valid = v; in_tag = TAG_W'(tag); in_multi = m; in_branch = b;
        in_cond = c; in_sets_cc = s; in_taken = t; in_target = TAG_W'(tgt);
        @(negedge clk);
    endtask

    task automatic plain(int tag); offer(1, tag, 0, 0, 0, 0, 0, 0); endtask
    task automatic idle();         offer(0, 0, 0, 0, 0, 0, 0, 0);   endtask
    task automatic flush();        for (int k = 0; k < 5; k++) idle(); endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(); idle();
        chk("R1", "valid after reset", int'(stg_vld_o), 0);
        chk("R1", "fetch_en after reset", int'(fetch_en_o), 1);
        chk("R1", "redirect after reset", int'(redirect_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_flow();
        plain(1); plain(2); plain(3); plain(4);
        chk("R2", "all stages valid", int'(stg_vld_o), 'hF);
        chk("R2", "tags IF..WB", (tag_at(0) << 24) | (tag_at(1) << 16) | (tag_at(2) << 8) | tag_at(3),
            'h04030201);
        idle();
        chk("R2", "bubble into IF", int'(stg_vld_o), 'hE);
        flush();
    endtask

    task automatic t_multi();
        offer(1, 'h10, 1, 0, 0, 0, 0, 0);
        plain('h11); plain('h12);
        chk("R3", "fetch_en low, multi in EX", int'(fetch_en_o), 0);
        plain('h13);
        chk("R3", "frozen, WB empty", int'(stg_vld_o), 'h7);
        chk("R3", "IF ignored new offer", tag_at(0), 'h12);
        chk("R3", "still held", int'(fetch_en_o), 0);
        plain('h13);
        chk("R3", "EX still multi", tag_at(2), 'h10);
        chk("R3", "released after MC_CYC", int'(fetch_en_o), 1);
        plain('h13);
        chk("R3", "multi reaches WB", (int'(stg_vld_o[3]) << 8) | tag_at(3), 'h110);
        chk("R3", "IF takes held offer", tag_at(0), 'h13);
        flush();
    endtask

    task automatic t_cc();
        offer(1, 'h20, 0, 0, 0, 1, 0, 0);
        offer(1, 'h21, 0, 1, 1, 0, 0, 0);
        idle(); idle();
        chk("R4", "cc wait stalls", int'(fetch_en_o), 0);
        chk("R4", "EX and WB valid", int'(stg_vld_o), 'hC);
        idle();
        chk("R4", "one stall cycle only", int'(fetch_en_o), 1);
        chk("R4", "bubble into WB", int'(stg_vld_o), 'h4);
        idle();
        chk("R4", "branch reaches WB", tag_at(3), 'h21);
        chk("R7", "not taken: no redirect", int'(redirect_o), 0);
        plain('h22);
        offer(1, 'h23, 0, 1, 1, 0, 0, 0);
        idle(); idle();
        chk("R4", "no producer, no stall", int'(fetch_en_o), 1);
        flush();
    endtask

    task automatic t_taken_id_slot();
        offer(1, 'h30, 0, 1, 0, 0, 1, 'h80);
        plain('h31); plain('h32);
        chk("R5", "redirect strobe", int'(redirect_o), 1);
        chk("R5", "redirect target", int'(redirect_tag_o), 'h80);
        plain('h33);
        chk("R5", "strobe one cycle", int'(redirect_o), 0);
        chk("R6", "slot kept, IF/ID squashed", int'(stg_vld_o), 'hC);
        chk("R6", "slot in EX", tag_at(2), 'h31);
        plain('h80);
        chk("R6", "target in IF", int'(stg_vld_o), 'h9);
        idle();
        chk("R9", "squashed 0x32 not in WB", int'(stg_vld_o[3]), 0);
        idle();
        chk("R9", "squashed 0x33 not in WB", int'(stg_vld_o[3]), 0);
        idle();
        chk("R6", "target reaches WB", (int'(stg_vld_o[3]) << 8) | tag_at(3), 'h180);
        flush();
    endtask

    task automatic t_taken_if_slot();
        offer(1, 'h40, 0, 1, 0, 0, 1, 'h90);
        idle();
        plain('h41);
        chk("R5", "redirect with ID empty", int'(redirect_o), 1);
        plain('h42);
        chk("R6", "IF slot kept, offer squashed", int'(stg_vld_o), 'hA);
        chk("R6", "slot in ID", tag_at(1), 'h41);
        flush();
    endtask

    task automatic t_not_taken();
        offer(1, 'h50, 0, 1, 0, 0, 0, 'hEE);
        plain('h51); plain('h52);
        chk("R7", "no redirect", int'(redirect_o), 0);
        plain('h53);
        chk("R7", "nothing squashed", int'(stg_vld_o), 'hF);
        flush();
    endtask

    task automatic t_multi_slot();
        offer(1, 'h60, 0, 1, 0, 0, 1, 'hA0);
        offer(1, 'h61, 1, 0, 0, 0, 0, 0);
        plain('h62);
        plain('h63);
        chk("R8", "multi slot kept in EX", (int'(stg_vld_o) << 8) | tag_at(2), 'hC61);
        chk("R8", "multi slot holds", int'(fetch_en_o), 0);
        plain('hA0);
        chk("R8", "second held cycle", int'(fetch_en_o), 0);
        plain('hA0);
        chk("R8", "released after MC_CYC", int'(fetch_en_o), 1);
        plain('hA0);
        chk("R8", "slot completes", (int'(stg_vld_o[3]) << 8) | tag_at(3), 'h161);
        chk("R8", "target fetched", tag_at(0), 'hA0);
        flush();
    endtask

    task automatic t_squashed_cc();
        offer(1, 'h70, 0, 1, 0, 0, 1, 'hB0);
        plain('h71);
        offer(1, 'h72, 0, 0, 0, 1, 0, 0);
        plain('h73);
        offer(1, 'hB0, 0, 1, 1, 0, 0, 0);
        idle(); idle();
        chk("R9", "no stall on squashed cc", int'(fetch_en_o), 1);
        chk("R9", "WB holds no squashed entry", int'(stg_vld_o), 'h4);
        idle();
        chk("R9", "branch completes", (int'(stg_vld_o[3]) << 8) | tag_at(3), 'h1B0);
        flush();
    endtask

    task automatic t_reset_midrun();
        plain(5); plain(6); plain(7);
        rst_n = 1'b0;
        plain(8);
        chk("R1", "reset clears full pipe", int'(stg_vld_o), 0);
        rst_n = 1'b1;
        idle();
    endtask

    initial begin
        rst_n = 1'b0;
        in_valid = 0; in_tag = '0; in_multi = 0; in_branch = 0;
        in_cond = 0; in_sets_cc = 0; in_taken = 0; in_target = '0;
        @(negedge clk);
        t_reset();
        t_flow();
        t_multi();
        t_cc();
        t_taken_id_slot();
        t_taken_if_slot();
        t_not_taken();
        t_multi_slot();
        t_squashed_cc();
        t_reset_midrun();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule